// File: doc/BRIEF.md
# Four-Block Configurable Memory Fabric

This block is an on-chip memory that can be reshaped after manufacture. It holds four storage blocks of 1 Kbit each. Every block can be set to one of four shapes, from 1024 words of 1 bit to 128 words of 8 bits. A routing layer then joins blocks into larger logical memories, either stacked for more words or placed side by side for wider words. Up to four independent memories can be built, one on each of the four external ports. Each port has an address, write data, a write strobe and registered read data.

The routing switches whole buses with a single flag per connection. It is arranged in two levels: blocks 0/1 and blocks 2/3 form pairs, and a top-level flag joins both pairs into one memory on port 0. When blocks are stacked, the address bits above the block's own range are decoded into one-hot block enables. In the mirrored (pseudo dual-port) pairing, one port writes both blocks of a pair at once, and each block is read back on its own port.

The shape and routing settings arrive serially on a dedicated configuration clock. A load strobe commits them to an active copy.

Top module: `fcm_fabric`

## Requirements
- R1: After reset, every read-data port is zero and the active settings are all zero. That means four independent 1024x1 memories, port p on block p.
- R2: Serial bits shift in on the rising edge of `cfg_clk`, most significant first, while `cfg_load` is low. The 40-bit chain is laid out as follows: block b's shape is at bits [33+2b:32+2b]; the routing flags are at bits 31..24; bits 23..0 are ignored. A rising `cfg_clk` edge with `cfg_load` high copies the chain into the active settings. At any other time the active settings stay as they are.
- R3: Shape code m (0..3) gives words of 2^m bits and 10-m address bits. Address bits [6:0] pick the row. The next 3-m bits pick a lane, which occupies row bits [lane*2^m +: 2^m]. Higher address bits are ignored. Read data appears one cycle after the address and shows the contents before any write in that same cycle.
- R4: A write narrower than 8 bits changes only its own lane. The other bits of the row keep their values.
- R5: The routing flags are bit 24 join pair 0/1, bit 25 join pair 2/3, bit 26 join all, bit 27 stack pair 0/1, bit 28 stack pair 2/3, bit 29 stack at top, bit 30 mirror pair 0/1, bit 31 mirror pair 2/3. A joined, unstacked pair is served on its lower port. The lower block carries data bits [w-1:0] and the upper block carries bits [2w-1:w], where w is the block word width.
- R6: In a joined, stacked pair, the address bit just above the block's range selects the lower or the upper block. Only the selected block is written.
- R7: When all four blocks are joined and stacked at both levels with shape 0, the memory is 4096x1 on port 0. Address bits [11:10] select the block, and exactly one block is written.
- R8: When all four are joined, bit 27 sets the arrangement inside both pairs and bit 29 sets the arrangement between the pairs. An inner stack with an outer width places block 2k+d at lane k and depth d. An inner width with an outer stack places block 2d+k at lane k and depth d.
- R9: Blocks in a joined group all take the shape of the group's lowest-numbered block. The shape fields of the other members have no effect.
- R10: A port that serves no memory under the current settings ignores its write strobe and returns zero read data.
- R11: In a joined pair with its mirror flag set, a write on the lower port updates the same location in both blocks. The upper port's write strobe is ignored. The upper port reads the upper block at its own address, except in a cycle where the lower port writes; in that cycle the upper block takes the lower port's address.
- R12: For stacked memories, read data comes from the block chosen by the address of the previous cycle, even when the address moves to another block in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset, sampled on both clocks |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_din | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Commit the chain to the active settings |
| port_addr | input | 4x12 | Address of each external port |
| port_wdata | input | 4x32 | Write data of each external port |
| port_we | input | 4 | Write strobe of each external port |
| port_rdata | output | 4x32 | Registered read data of each external port |

## Verification
Two cases are hard to reach. The first is the mirrored pairing, in the cycle where the lower port writes while the upper port reads: the upper block's address source switches for exactly that cycle. The second is stacked memories whose address jumps between blocks on every cycle. Both arise only after a complete 40-bit shift and load, and only once the memory holds known contents. The stimulus therefore first fills every row through a byte-wide setting. It then reloads a series of settings and, under each, drives independent random strobes and addresses on all four ports. In those runs, same-cycle write/read collisions and block switches from one cycle to the next occur hundreds of times.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    localparam int NBLK     = 4;
    localparam int NPORT    = 4;
    localparam int CFG_LEN  = 40;
    localparam int CFG_KEEP = 16;
    localparam int SHAPE_W  = 2;

    typedef logic [SHAPE_W-1:0] shape_t;

    // bit 24 of the chain is the least significant member
    typedef struct packed {
        logic mirror_hi;
        logic mirror_lo;
        logic stack_top;
        logic stack_hi;
        logic stack_lo;
        logic join_all;
        logic join_hi;
        logic join_lo;
    } route_t;

    typedef struct packed {
        shape_t [NBLK-1:0] shape;
        route_t            route;
    } fabric_cfg_t;

    // where one block sits inside its logical memory
    typedef struct packed {
        logic [1:0] lead;    // port that addresses and writes the block
        logic [1:0] rport;   // port that receives its read data
        logic [1:0] didx;    // depth slot
        logic [1:0] widx;    // lane slot
        logic [1:0] dbits;   // number of depth-select address bits
        shape_t     shape;   // effective shape (group leader's)
        logic       mirror;  // upper block of a mirrored pair
    } place_t;

    function automatic int lane_ones(shape_t m);
        return (1 << (1 << m)) - 1;
    endfunction

    function automatic place_t place_of(fabric_cfg_t c, int b);
        place_t p;
        logic   inner;
        logic   outer;
        logic   joined;
        logic   stacked;
        logic   mirrored;
        inner    = b[0];
        outer    = b[1];
        p.lead   = 2'(b);
        p.rport  = 2'(b);
        p.didx   = 2'd0;
        p.widx   = 2'd0;
        p.dbits  = 2'd0;
        p.shape  = c.shape[b];
        p.mirror = 1'b0;
        if (c.route.join_all) begin
            p.lead  = 2'd0;
            p.rport = 2'd0;
            p.shape = c.shape[0];
            case ({c.route.stack_lo, c.route.stack_top})
                2'b11: begin p.didx = 2'(b); p.dbits = 2'd2; end
                2'b00: begin p.widx = 2'(b); end
                2'b10: begin p.didx = {1'b0, inner}; p.widx = {1'b0, outer}; p.dbits = 2'd1; end
                default: begin p.didx = {1'b0, outer}; p.widx = {1'b0, inner}; p.dbits = 2'd1; end
            endcase
        end else begin
            joined   = outer ? c.route.join_hi   : c.route.join_lo;
            stacked  = outer ? c.route.stack_hi  : c.route.stack_lo;
            mirrored = outer ? c.route.mirror_hi : c.route.mirror_lo;
            if (joined) begin
                p.lead  = {outer, 1'b0};
                p.shape = c.shape[{outer, 1'b0}];
                if (mirrored) begin
                    p.rport  = 2'(b);
                    p.mirror = inner;
                end else begin
                    p.rport = {outer, 1'b0};
                    if (stacked) begin
                        p.didx  = {1'b0, inner};
                        p.dbits = 2'd1;
                    end else begin
                        p.widx = {1'b0, inner};
                    end
                end
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/fcm_cfg_chain.sv
module fcm_cfg_chain
    import fcm_pkg::*;
#(
    parameter int LEN  = CFG_LEN,
    parameter int KEEP = CFG_KEEP
) (
    input  logic        cfg_clk,
    input  logic        rst,
    input  logic        cfg_din,
    input  logic        cfg_load,
    output fabric_cfg_t active
);

    logic [LEN-1:0]  chain;
    logic [KEEP-1:0] held;

    always_ff @(posedge cfg_clk) begin
        if (rst) begin
            chain <= '0;
            held  <= '0;
        end else if (cfg_load) begin
            held <= chain[LEN-1 -: KEEP];
        end else begin
            chain <= {chain[LEN-2:0], cfg_din};
        end
    end

    assign active = fabric_cfg_t'(held);

    // R2: settings only move on a load edge
    a_r2_hold_between_loads: assert property (@(posedge cfg_clk) disable iff (rst)
        !cfg_load |=> $stable(active));

    // R2: the chain pauses while it is being committed
    a_r2_chain_paused: assert property (@(posedge cfg_clk) disable iff (rst)
        cfg_load |=> $stable(chain));

endmodule

// File: rtl/fcm_route.sv
module fcm_route
    import fcm_pkg::*;
#(
    parameter int N = NBLK
) (
    input  fabric_cfg_t         cfg,
    output place_t [N-1:0]      plc
);

    for (genvar b = 0; b < N; b++) begin : g_place
        assign plc[b] = place_of(cfg, b);
    end

endmodule

// File: rtl/fcm_block.sv
module fcm_block
    import fcm_pkg::*;
#(
    parameter int ROWS = 128,
    parameter int RW   = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  shape_t                         shape,
    input  logic [$clog2(ROWS*RW)-1:0]     addr,
    input  logic [RW-1:0]                  wdata,
    input  logic                           we,
    output logic [RW-1:0]                  rdata
);

    localparam int ABITS = $clog2(ROWS * RW);
    localparam int RAW   = $clog2(ROWS);
    localparam int SW    = ABITS - RAW;

    logic [RW-1:0]  mem [ROWS];
    logic [RAW-1:0] row;
    logic [SW-1:0]  lane;
    logic [RW-1:0]  lmask;
    logic [RW-1:0]  wmask;
    logic [RW-1:0]  wrep;
    logic [RW-1:0]  rd_q;
    logic [SW-1:0]  lane_q;

    always_comb begin
        row   = addr[RAW-1:0];
        lane  = addr[ABITS-1:RAW] & SW'((1 << (SW - int'(shape))) - 1);
        lmask = RW'(lane_ones(shape));
        wmask = lmask << (int'(lane) << shape);
        for (int i = 0; i < RW; i++) begin
            wrep[i] = wdata[i & ((1 << shape) - 1)];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[row] <= (mem[row] & ~wmask) | (wrep & wmask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            lane_q <= '0;
        end else begin
            rd_q   <= mem[row];
            lane_q <= lane;
        end
    end

    assign rdata = (rd_q >> (int'(lane_q) << shape)) & lmask;

    // R4: bits outside the written lane keep their value
    a_r4_other_lanes_kept: assert property (@(posedge clk) disable iff (rst)
        we |=> ((mem[$past(row)] & ~$past(wmask)) == ($past(mem[row]) & ~$past(wmask))));

endmodule

// File: rtl/fcm_fabric.sv
module fcm_fabric
    import fcm_pkg::*;
#(
    parameter int ROWS = 128,
    parameter int RW   = 8,
    parameter int PAW  = $clog2(ROWS * RW) + 2,
    parameter int PDW  = RW * NBLK
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_clk,
    input  logic                        cfg_din,
    input  logic                        cfg_load,
    input  logic [NPORT-1:0][PAW-1:0]   port_addr,
    input  logic [NPORT-1:0][PDW-1:0]   port_wdata,
    input  logic [NPORT-1:0]            port_we,
    output logic [NPORT-1:0][PDW-1:0]   port_rdata
);

    localparam int ABITS = $clog2(ROWS * RW);
    localparam int SHW   = $clog2(PDW);

    fabric_cfg_t              cfg;
    place_t [NBLK-1:0]        plc;
    logic   [NBLK-1:0]        blk_we;
    logic   [NBLK-1:0]        blk_be;
    logic   [NBLK-1:0]        rd_be_q;
    logic   [NBLK-1:0][RW-1:0] blk_rd;
    logic   [NBLK-1:0][SHW-1:0] shamt;

    fcm_cfg_chain #(.LEN(CFG_LEN), .KEEP(CFG_KEEP)) u_chain (
        .cfg_clk (cfg_clk),
        .rst     (rst),
        .cfg_din (cfg_din),
        .cfg_load(cfg_load),
        .active  (cfg)
    );

    fcm_route #(.N(NBLK)) u_route (
        .cfg(cfg),
        .plc(plc)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        place_t         pl;
        logic [1:0]     asrc;
        logic [PAW-1:0] a;
        logic [1:0]     up;
        logic [1:0]     dsel;
        logic [RW-1:0]  wd;

        assign pl = plc[b];

        always_comb begin
            asrc = pl.lead;
            if (pl.mirror && !port_we[pl.lead]) begin
                asrc = 2'(b);
            end
            a  = port_addr[asrc];
            up = 2'(a >> (ABITS - int'(pl.shape)));
            case (pl.dbits)
                2'd0:    dsel = 2'd0;
                2'd1:    dsel = {1'b0, up[0]};
                default: dsel = up;
            endcase
            shamt[b] = SHW'(int'(pl.widx) << pl.shape);
            wd       = RW'(port_wdata[pl.lead] >> shamt[b]);
        end

        assign blk_be[b] = (dsel == pl.didx);
        assign blk_we[b] = port_we[pl.lead] & blk_be[b];

        fcm_block #(.ROWS(ROWS), .RW(RW)) u_block (
            .clk  (clk),
            .rst  (rst),
            .shape(pl.shape),
            .addr (a[ABITS-1:0]),
            .wdata(wd),
            .we   (blk_we[b]),
            .rdata(blk_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_be_q <= '0;
        end else begin
            rd_be_q <= blk_be;
        end
    end

    always_comb begin
        port_rdata = '0;
        for (int b = 0; b < NBLK; b++) begin
            for (int p = 0; p < NPORT; p++) begin
                if (rd_be_q[b] && plc[b].rport == 2'(p)) begin
                    port_rdata[p] = port_rdata[p] | (PDW'(blk_rd[b]) << shamt[b]);
                end
            end
        end
    end

    // R7: a fully stacked fabric writes at most one block per cycle
    a_r7_single_block_written: assert property (@(posedge clk) disable iff (rst)
        (cfg.route.join_all && cfg.route.stack_lo && cfg.route.stack_top) |-> $onehot0(blk_we));

    // R11: both halves of a mirrored pair take the same write
    a_r11_mirror_writes_both: assert property (@(posedge clk) disable iff (rst)
        (!cfg.route.join_all && cfg.route.join_lo && cfg.route.mirror_lo)
        |-> (blk_we[0] == blk_we[1]));

    // R11: the upper port of a mirrored pair never starts a write
    a_r11_upper_port_no_write: assert property (@(posedge clk) disable iff (rst)
        (!cfg.route.join_all && cfg.route.join_hi && cfg.route.mirror_hi && !port_we[2])
        |-> (blk_we[3:2] == 2'b00));

    // R10: the spare port of a joined pair stays silent
    a_r10_idle_port_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cfg.route.join_all && cfg.route.join_lo && !cfg.route.mirror_lo)
        |-> (port_rdata[1] == '0));

endmodule

// File: tb/fcm_fabric_bench.sv
module fcm_fabric_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_clk = 1'b0;
    logic cfg_din = 1'b0;
    logic cfg_load = 1'b0;
    logic [3:0][11:0] addr;
    logic [3:0][31:0] wdata;
    logic [3:0]       we;
    logic [3:0][31:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural model state
    logic [7:0] mm [4][128];
    int md [4];
    bit jl, jh, ja, sl, sh2, st, ml, mh;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcm_fabric u_fcm_fabric (
        .clk       (clk),
        .rst       (rst),
        .cfg_clk   (cfg_clk),
        .cfg_din   (cfg_din),
        .cfg_load  (cfg_load),
        .port_addr (addr),
        .port_wdata(wdata),
        .port_we   (we),
        .port_rdata(rdata)
    );

    function automatic logic [39:0] mk(int m0, int m1, int m2, int m3, logic [7:0] fl,
                                       logic [23:0] junk);
        return {2'(m3), 2'(m2), 2'(m1), 2'(m0), fl, junk};
    endfunction

    function automatic void decode(logic [39:0] v);
        for (int b = 0; b < 4; b++) md[b] = int'(v[32 + 2*b +: 2]);
        jl = v[24]; jh = v[25]; ja = v[26]; sl = v[27];
        sh2 = v[28]; st = v[29]; ml = v[30]; mh = v[31];
    endfunction

    // logical bit j of port p at address a -> physical cell
    function automatic bit locate(int p, int a, int j, bit rd,
                                  output int blk, output int row, output int pos);
        int m, wb, ab, dd, ww, loc, dsel, lane, q;
        bit jn, stk, mir;
        dd = 1; ww = 1;
        blk = 0; row = 0; pos = 0;
        q = p / 2;
        jn  = q ? jh : jl;
        stk = q ? sh2 : sl;
        mir = q ? mh : ml;
        if (ja) begin
            if (p != 0) return 0;
            m = md[0];
            if (sl && st) dd = 4;
            else if (!sl && !st) ww = 4;
            else begin dd = 2; ww = 2; end
        end else if (jn) begin
            m = md[2*q];
            if (mir) begin
                if (p % 2 == 1 && !rd) return 0;
            end else begin
                if (p % 2 == 1) return 0;
                if (stk) dd = 2; else ww = 2;
            end
        end else begin
            m = md[p];
        end
        wb   = 1 << m;
        ab   = 10 - m;
        loc  = a % (1 << ab);
        dsel = (a >> ab) % dd;
        lane = j / wb;
        if (lane >= ww) return 0;
        if (ja) begin
            if (sl && st)        blk = dsel;
            else if (!sl && !st) blk = lane;
            else if (sl)         blk = lane * 2 + dsel;
            else                 blk = dsel * 2 + lane;
        end else if (jn) begin
            if (mir) blk = rd ? p : 2*q;
            else if (stk) blk = 2*q + dsel;
            else blk = 2*q + lane;
        end else begin
            blk = p;
        end
        row = loc % 128;
        pos = (loc / 128) * wb + (j % wb);
        return 1;
    endfunction

    task automatic step(input string tag, input bit chk);
        logic [3:0][31:0] ex;
        int b, r, s, ra;
        bit mirp;
        for (int p = 0; p < 4; p++) begin
            ex[p] = '0;
            ra = int'(addr[p]);
            mirp = !ja && ((p / 2) ? (jh && mh) : (jl && ml));
            if (mirp && p % 2 == 1 && we[p-1]) ra = int'(addr[p-1]);
            for (int j = 0; j < 32; j++) begin
                if (locate(p, ra, j, 1'b1, b, r, s)) ex[p][j] = mm[b][r][s];
            end
        end
        for (int p = 0; p < 4; p++) begin
            if (we[p]) begin
                mirp = !ja && ((p / 2) ? (jh && mh) : (jl && ml));
                for (int j = 0; j < 32; j++) begin
                    if (locate(p, int'(addr[p]), j, 1'b0, b, r, s)) begin
                        mm[b][r][s] = wdata[p][j];
                        if (mirp) mm[b+1][r][s] = wdata[p][j];
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        if (chk) begin
            for (int p = 0; p < 4; p++) begin
                n_cmp++;
                if (rdata[p] !== ex[p]) begin
                    n_bad++;
                    $display("FAIL %s port %0d: got %h expected %h", tag, p, rdata[p], ex[p]);
                end
            end
        end
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            for (int p = 0; p < 4; p++) begin
                addr[p]  = 12'($urandom);
                wdata[p] = $urandom;
                we[p]    = 1'($urandom % 2);
            end
            step(tag, 1'b1);
        end
        we = '0;
    endtask

    task automatic shift_cfg(input logic [39:0] v, input bit commit);
        we = '0;
        for (int i = 39; i >= 0; i--) begin
            cfg_din = v[i];
            #1 cfg_clk = 1'b1;
            #1 cfg_clk = 1'b0;
        end
        if (commit) begin
            cfg_load = 1'b1;
            #1 cfg_clk = 1'b1;
            #1 cfg_clk = 1'b0;
            cfg_load = 1'b0;
            decode(v);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        we = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cfg_clk = 1'b1;
            #1 cfg_clk = 1'b0;
        end
        @(negedge clk);
        rst = 1'b0;
        decode('0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        summary();
        $finish;
    end

    initial begin
        addr = '0; wdata = '0; we = '0;
        do_reset();

        // R1: read data is zero straight after reset
        for (int p = 0; p < 4; p++) begin
            n_cmp++;
            if (rdata[p] !== 32'd0) begin
                n_bad++;
                $display("FAIL R1 reset port %0d: got %h expected %h", p, rdata[p], 32'd0);
            end
        end

        // fill every row through byte-wide single blocks (R3 setup)
        shift_cfg(mk(3, 3, 3, 3, 8'h00, 24'h0), 1'b1);
        for (int r = 0; r < 128; r++) begin
            for (int p = 0; p < 4; p++) begin
                addr[p]  = 12'(r);
                wdata[p] = $urandom;
                we[p]    = 1'b1;
            end
            step("R3 fill", 1'b0);
        end
        we = '0;
        run("R3 bytewide", 60);

        // R1: after a new reset the fabric is four 1024x1 memories
        do_reset();
        run("R1 default shape", 200);

        // R3 R4: one shape per block, narrow writes keep other lanes
        shift_cfg(mk(0, 1, 2, 3, 8'h00, 24'h0), 1'b1);
        run("R3 R4 mixed shapes", 300);

        // R5 R9 R10: side-by-side pairs, member shape ignored
        shift_cfg(mk(2, 0, 1, 3, 8'b0000_0011, 24'h0), 1'b1);
        run("R5 R9 R10 wide pairs", 300);

        // R6 R12 R10: stacked pairs
        shift_cfg(mk(1, 3, 0, 2, 8'b0001_1011, 24'h0), 1'b1);
        run("R6 R12 R10 deep pairs", 300);

        // R7 R12: 4096x1
        shift_cfg(mk(0, 0, 0, 0, 8'b0010_1100, 24'h0), 1'b1);
        run("R7 R12 full stack", 300);

        // R8: both mixed arrangements and the all-wide arrangement
        shift_cfg(mk(1, 0, 0, 0, 8'b0000_1100, 24'h0), 1'b1);
        run("R8 inner stack outer wide", 200);
        shift_cfg(mk(2, 0, 0, 0, 8'b0010_0100, 24'h0), 1'b1);
        run("R8 inner wide outer stack", 200);
        shift_cfg(mk(3, 1, 1, 1, 8'b0000_0100, 24'h0), 1'b1);
        run("R8 all wide", 200);

        // R11: both pairs mirrored
        shift_cfg(mk(3, 0, 1, 2, 8'b1100_0011, 24'h0), 1'b1);
        run("R11 mirrored pairs", 400);

        // R2: shifting without a load leaves the active settings alone
        shift_cfg(mk(0, 0, 0, 0, 8'b0010_1100, 24'hA5A5A5), 1'b0);
        run("R2 shift without load", 150);

        // R2: ignored chain bits set to ones have no effect once loaded
        shift_cfg(mk(2, 1, 0, 3, 8'b0000_0010, 24'hFFFFFF), 1'b1);
        run("R2 ignored bits", 200);

        summary();
        $finish;
    end

endmodule